// File: doc/BRIEF.md
# Multi-lane timestamped event dispatcher

This block takes a single stream of timed events and releases each one on an output channel at the moment a free-running time counter reaches the event's timestamp. Every event carries a channel number, a timestamp and a data word. The source may write events whose timestamps step backwards relative to earlier writes, for example when several actions of one group start at the same instant. The block handles this by spreading the writes across a set of parallel lane queues. Within one lane, timestamps must rise strictly.

A lane selector remembers the newest timestamp it has put into each lane. It stays on its current lane while timestamps keep rising. When a timestamp does not rise, the selector moves forward, with wrap-around, to the first lane that can take the event. When no lane can take the event, the event is discarded and a sticky sequence-error flag is set, together with the channel of that event. The source is never halted by such an error.

At the head of each lane, a due event is handed to its channel. When two lane heads address the same channel in the same cycle, the lower-numbered lane goes first and the other lane waits one cycle. Late-event detection at the source and the channel drivers themselves belong to other blocks.

Top module: `evt_lane_dispatcher`

## Requirements
- R1: While reset is applied and in the first cycle after it, every channel strobe is low, the error flag is clear, `cur_time` reads 0 and `in_ready` is high.
- R2: After reset is released, `cur_time` increases by exactly one every clock cycle.
- R3: Take an event with timestamp T that is accepted in a cycle where `cur_time` reads W, with T > W. Its channel strobe is high for one cycle, carrying the event's data, in the cycle where `cur_time` reads T+1.
- R4: Events written with timestamps lower than earlier writes are still each delivered at their own timestamp, as in R3.
- R5: A lane only takes an event whose timestamp is greater than the newest timestamp already in that lane, unless the lane is empty. So up to LANES events with one identical timestamp are all queued, and they leave on consecutive cycles.
- R6: An event that no lane can take is discarded and never delivered. `in_ready` stays high for it. The error flag rises and `seq_err_chan` takes that event's channel number.
- R7: The error flag stays set until `err_clear` is high in a cycle with no new error. A new error in the same cycle as `err_clear` wins, so the flag stays set.
- R8: Two due events in different lanes that target the same channel leave in lane order. The lower-numbered lane drives its strobe at T+1 and the other lane drives its strobe at T+2.
- R9: A lane holds at most LANE_DEPTH events. When the chosen lane is full, `in_ready` is low and the event is held at the input. The event is accepted once that lane releases an entry, and it is then delivered normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An event is offered |
| in_ready | output | 1 | The event is taken at this edge (low only when the chosen lane is full) |
| in_chan | input | $clog2(CHANS) | Target channel of the offered event |
| in_ts | input | TS_W | Timestamp of the offered event |
| in_data | input | DATA_W | Data word of the offered event |
| err_clear | input | 1 | Clears the sequence-error flag |
| cur_time | output | TS_W | Current value of the time counter |
| chan_strobe | output | CHANS | One bit per channel, high for one cycle when an event is delivered |
| chan_data | output | CHANS*DATA_W | Data word per channel; channel c occupies bits c*DATA_W upward |
| seq_err_flag | output | 1 | Sticky sequence-error flag |
| seq_err_chan | output | $clog2(CHANS) | Channel number of the most recent discarded event |

## Verification
The hardest state to reach from the ports is one where every lane holds an event with the same timestamp, so that the selector has nowhere left to go. The stimulus gets there by writing nine events with one identical far-future timestamp. The ninth event must then be dropped with `in_ready` still high, and the eight queued events must leave on eight consecutive cycles. A second hard case is a full lane. Nine rising timestamps are written to one lane, which fills it, and the test waits until the first entry drains so that the held event can enter. The same-channel collision is checked right after reset. At that point the lane order of the two colliding writes is known, so the bench can predict which lane leaves first.

// File: rtl/evd_pkg.sv
package evd_pkg;

   // Outcome of the lane search for the event offered at the input
   typedef enum logic [1:0] {
      PICK_NONE    = 2'd0,   // no lane can take it: sequence error
      PICK_OPEN    = 2'd1,   // a lane takes it this cycle
      PICK_BLOCKED = 2'd2    // chosen lane has no free slot: stall
   } pick_e;

   // Modular increment for lane indices that need not be powers of two
   function automatic int unsigned wrap_add(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned n);
      int unsigned s;
      s = a + b;
      return (s >= n) ? s - n : s;
   endfunction

endpackage

// File: rtl/evd_lane_fifo.sv
module evd_lane_fifo #(
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned ENTRY_W = 34,
   parameter int unsigned TS_W    = 24,
   parameter int unsigned TS_LSB  = 8,
   localparam int unsigned AW     = $clog2(DEPTH),
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [ENTRY_W-1:0] wdata,
   input  logic               pop,
   output logic [ENTRY_W-1:0] head,
   output logic               empty,
   output logic               full,
   output logic [CNT_W-1:0]   count,
   output logic [TS_W-1:0]    last_ts
);

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [AW-1:0]      wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   initial begin : param_check
      if (DEPTH < 2) $fatal(1, "evd_lane_fifo: DEPTH must be at least 2");
      if (TS_LSB + TS_W > ENTRY_W) $fatal(1, "evd_lane_fifo: timestamp field outside entry");
   end

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_mod
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         last_ts <= '0;
      end else begin
         if (push) begin
            wr_ptr  <= wr_nxt;
            last_ts <= wdata[TS_LSB +: TS_W];
         end
         if (pop) rd_ptr <= rd_nxt;
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign head  = mem[rd_ptr];
   assign empty = (count == '0);
   assign full  = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/evd_lane_select.sv
module evd_lane_select
   import evd_pkg::*;
#(
   parameter int unsigned LANES = 8,
   parameter int unsigned TS_W  = 24,
   localparam int unsigned LW   = $clog2(LANES)
) (
   input  logic [LW-1:0]                cur,
   input  logic [TS_W-1:0]              req_ts,
   input  logic [LANES-1:0][TS_W-1:0]   last_ts,
   input  logic [LANES-1:0]             empty,
   input  logic [LANES-1:0]             full,
   output logic [LW-1:0]                pick,
   output pick_e                        status
);

   logic hit;

   // Scan forward from the current lane, wrapping, for the first lane
   // that keeps its timestamps strictly rising.
   always_comb begin
      hit  = 1'b0;
      pick = cur;
      for (int unsigned k = 0; k < LANES; k++) begin
         int unsigned j;
         j = wrap_add(int'(cur), k, LANES);
         if (!hit && (empty[j] || (req_ts > last_ts[j]))) begin
            hit  = 1'b1;
            pick = LW'(j);
         end
      end
   end

   always_comb begin
      if (!hit)            status = PICK_NONE;
      else if (full[pick]) status = PICK_BLOCKED;
      else                 status = PICK_OPEN;
   end

endmodule

// File: rtl/evd_chan_arb.sv
module evd_chan_arb #(
   parameter int unsigned LANES  = 8,
   parameter int unsigned CHANS  = 4,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned CHAN_W = $clog2(CHANS)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [LANES-1:0]                due,
   input  logic [LANES-1:0][CHAN_W-1:0]    head_chan,
   input  logic [LANES-1:0][DATA_W-1:0]    head_data,
   output logic [LANES-1:0]                pop,
   output logic [CHANS-1:0]                strobe,
   output logic [CHANS-1:0][DATA_W-1:0]    data
);

   logic [CHANS-1:0][LANES-1:0] grant;

   generate
      for (genvar c = 0; c < CHANS; c++) begin : g_chan
         logic [LANES-1:0]  match;
         logic [LANES-1:0]  win;
         logic [DATA_W-1:0] sel_d;
         logic              str_q;
         logic [DATA_W-1:0] dat_q;

         always_comb begin
            for (int l = 0; l < LANES; l++)
               match[l] = due[l] && (head_chan[l] == CHAN_W'(c));
         end

         // lowest-numbered requesting lane wins
         assign win = match & (~match + 1'b1);

         always_comb begin
            sel_d = '0;
            for (int l = 0; l < LANES; l++)
               if (win[l]) sel_d = head_data[l];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               str_q <= 1'b0;
               dat_q <= '0;
            end else begin
               str_q <= |match;
               dat_q <= (|match) ? sel_d : '0;
            end
         end

         assign grant[c]  = win;
         assign strobe[c] = str_q;
         assign data[c]   = dat_q;
      end
   endgenerate

   always_comb begin
      pop = '0;
      for (int c = 0; c < CHANS; c++) pop = pop | grant[c];
   end

endmodule

// File: rtl/evt_lane_dispatcher.sv
module evt_lane_dispatcher
   import evd_pkg::*;
#(
   parameter int unsigned LANES      = 8,
   parameter int unsigned LANE_DEPTH = 8,
   parameter int unsigned CHANS      = 4,
   parameter int unsigned TS_W       = 24,
   parameter int unsigned DATA_W     = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic [$clog2(CHANS)-1:0]    in_chan,
   input  logic [TS_W-1:0]             in_ts,
   input  logic [DATA_W-1:0]           in_data,
   input  logic                        err_clear,
   output logic [TS_W-1:0]             cur_time,
   output logic [CHANS-1:0]            chan_strobe,
   output logic [CHANS*DATA_W-1:0]     chan_data,
   output logic                        seq_err_flag,
   output logic [$clog2(CHANS)-1:0]    seq_err_chan
);

   localparam int unsigned CHAN_W  = $clog2(CHANS);
   localparam int unsigned LW      = $clog2(LANES);
   localparam int unsigned CNT_W   = $clog2(LANE_DEPTH + 1);
   localparam int unsigned TS_LSB  = DATA_W;
   localparam int unsigned ENTRY_W = CHAN_W + TS_W + DATA_W;

   initial begin : param_check
      if (LANES < 2)  $fatal(1, "evt_lane_dispatcher: LANES must be at least 2");
      if (CHANS < 2)  $fatal(1, "evt_lane_dispatcher: CHANS must be at least 2");
      if (TS_W < 4)   $fatal(1, "evt_lane_dispatcher: TS_W too narrow");
      if (DATA_W < 1) $fatal(1, "evt_lane_dispatcher: DATA_W must be positive");
   end

   logic [TS_W-1:0]                 time_q;
   logic [LW-1:0]                   cur_q;
   logic [LW-1:0]                   pick;
   pick_e                           status;

   logic [LANES-1:0]                lane_push, lane_pop, lane_empty, lane_full, lane_due;
   logic [LANES-1:0][TS_W-1:0]      lane_last;
   logic [LANES-1:0][CNT_W-1:0]     lane_cnt;
   logic [LANES-1:0][ENTRY_W-1:0]   lane_head;
   logic [LANES-1:0][CHAN_W-1:0]    head_chan;
   logic [LANES-1:0][DATA_W-1:0]    head_data;
   logic [CHANS-1:0][DATA_W-1:0]    out_data;
   logic [ENTRY_W-1:0]              in_entry;
   logic                            err_hit;

   assign in_entry = {in_chan, in_ts, in_data};

   // free-running time base
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) time_q <= '0;
      else        time_q <= time_q + 1'b1;
   end
   assign cur_time = time_q;

   evd_lane_select #(
      .LANES (LANES),
      .TS_W  (TS_W)
   ) u_sel (
      .cur     (cur_q),
      .req_ts  (in_ts),
      .last_ts (lane_last),
      .empty   (lane_empty),
      .full    (lane_full),
      .pick    (pick),
      .status  (status)
   );

   assign in_ready = (status != PICK_BLOCKED);
   assign err_hit  = in_valid && (status == PICK_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  cur_q <= '0;
      else if (in_valid && status == PICK_OPEN)    cur_q <= pick;
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [TS_W-1:0] head_ts;

         assign lane_push[l] = in_valid && (status == PICK_OPEN) && (pick == LW'(l));

         evd_lane_fifo #(
            .DEPTH   (LANE_DEPTH),
            .ENTRY_W (ENTRY_W),
            .TS_W    (TS_W),
            .TS_LSB  (TS_LSB)
         ) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (lane_push[l]),
            .wdata   (in_entry),
            .pop     (lane_pop[l]),
            .head    (lane_head[l]),
            .empty   (lane_empty[l]),
            .full    (lane_full[l]),
            .count   (lane_cnt[l]),
            .last_ts (lane_last[l])
         );

         assign head_chan[l] = lane_head[l][ENTRY_W-1 -: CHAN_W];
         assign head_ts      = lane_head[l][TS_LSB +: TS_W];
         assign head_data[l] = lane_head[l][DATA_W-1:0];
         assign lane_due[l]  = !lane_empty[l] && (head_ts <= time_q);
      end
   endgenerate

   evd_chan_arb #(
      .LANES  (LANES),
      .CHANS  (CHANS),
      .DATA_W (DATA_W)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .due       (lane_due),
      .head_chan (head_chan),
      .head_data (head_data),
      .pop       (lane_pop),
      .strobe    (chan_strobe),
      .data      (out_data)
   );

   assign chan_data = out_data;

   // sticky sequence-error record; a new error outranks a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_err_flag <= 1'b0;
         seq_err_chan <= '0;
      end else if (err_hit) begin
         seq_err_flag <= 1'b1;
         seq_err_chan <= in_chan;
      end else if (err_clear) begin
         seq_err_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/evt_lane_dispatcher_chk.sv
module evt_lane_dispatcher_chk #(
   parameter int unsigned LANES      = 8,
   parameter int unsigned LANE_DEPTH = 8,
   parameter int unsigned CHANS      = 4,
   parameter int unsigned TS_W       = 24,
   localparam int unsigned CNT_W     = $clog2(LANE_DEPTH + 1)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        in_valid,
   input logic                        in_ready,
   input logic [TS_W-1:0]             in_ts,
   input logic                        err_clear,
   input logic                        seq_err_flag,
   input logic [TS_W-1:0]             cur_time,
   input logic [CHANS-1:0]            chan_strobe,
   input logic [LANES-1:0]            lane_push,
   input logic [LANES-1:0]            lane_empty,
   input logic [LANES-1:0][TS_W-1:0]  lane_last,
   input logic [LANES-1:0][CNT_W-1:0] lane_cnt
);

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (chan_strobe == '0 && !seq_err_flag && cur_time == '0)); // R1

   AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (cur_time == $past(cur_time) + 1'b1)); // R2

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_err_flag) |-> $past(in_valid && in_ready)); // R6

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_err_flag && !err_clear) |=> seq_err_flag); // R7

   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clear && !in_valid) |=> !seq_err_flag); // R7

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
         AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            lane_cnt[l] <= CNT_W'(LANE_DEPTH)); // R9

         AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_push[l] && !lane_empty[l]) |-> (in_ts > lane_last[l])); // R5
      end
   endgenerate

endmodule

bind evt_lane_dispatcher evt_lane_dispatcher_chk #(
   .LANES      (LANES),
   .LANE_DEPTH (LANE_DEPTH),
   .CHANS      (CHANS),
   .TS_W       (TS_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .in_ts        (in_ts),
   .err_clear    (err_clear),
   .seq_err_flag (seq_err_flag),
   .cur_time     (cur_time),
   .chan_strobe  (chan_strobe),
   .lane_push    (lane_push),
   .lane_empty   (lane_empty),
   .lane_last    (lane_last),
   .lane_cnt     (lane_cnt)
);

// File: tb/evt_lane_dispatcher_tb.sv
module evt_lane_dispatcher_tb;

   localparam int LANES  = 8;
   localparam int DEPTH  = 8;
   localparam int CHANS  = 4;
   localparam int TS_W   = 24;
   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [1:0]        in_chan = '0;
   logic [TS_W-1:0]   in_ts = '0;
   logic [DATA_W-1:0] in_data = '0;
   logic              err_clear = 1'b0;
   logic [TS_W-1:0]   cur_time;
   logic [CHANS-1:0]  chan_strobe;
   logic [CHANS*DATA_W-1:0] chan_data;
   logic              seq_err_flag;
   logic [1:0]        seq_err_chan;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   int lt [CHANS][64];
   int ld [CHANS][64];
   int ln [CHANS];

   always #10 clk = ~clk;   // 50 MHz

   evt_lane_dispatcher #(
      .LANES(LANES), .LANE_DEPTH(DEPTH), .CHANS(CHANS), .TS_W(TS_W), .DATA_W(DATA_W)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_chan(in_chan), .in_ts(in_ts), .in_data(in_data), .err_clear(err_clear),
      .cur_time(cur_time), .chan_strobe(chan_strobe), .chan_data(chan_data),
      .seq_err_flag(seq_err_flag), .seq_err_chan(seq_err_chan)
   );

   initial for (int c = 0; c < CHANS; c++) ln[c] = 0;

   // delivery log, taken away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < CHANS; c++) begin
            if (chan_strobe[c] && ln[c] < 64) begin
               lt[c][ln[c]] = int'(cur_time);
               ld[c][ln[c]] = int'(chan_data[c*DATA_W +: DATA_W]);
               ln[c] = ln[c] + 1;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at a falling edge after acceptance
   task automatic send(input int ch, input int ts, input int d, input bit clr, output bit stalled);
      in_valid  = 1'b1;
      in_chan   = ch[1:0];
      in_ts     = ts[TS_W-1:0];
      in_data   = d[DATA_W-1:0];
      err_clear = clr;
      stalled   = 1'b0;
      #1;
      while (!in_ready) begin
         stalled = 1'b1;
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      in_valid  = 1'b0;
      err_clear = 1'b0;
   endtask

   task automatic wait_time(input int t);
      while (int'(cur_time) < t) @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(chan_strobe == '0, "R1 strobes", int'(chan_strobe), 0);
      check(!seq_err_flag, "R1 err flag", int'(seq_err_flag), 0);
      check(cur_time == '0, "R1 time", int'(cur_time), 0);
      check(in_ready, "R1 ready", int'(in_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(cur_time == 1, "R2 first step", int'(cur_time), 1);
      @(negedge clk);
      check(cur_time == 2, "R2 second step", int'(cur_time), 2);
   endtask

   // right after reset: first write lands in lane 0, second in lane 1
   task automatic t_priority;
      int t;
      int b;
      bit st;
      t = int'(cur_time) + 20;
      b = ln[2];
      send(2, t, 'hA1, 0, st);
      send(2, t, 'hB2, 0, st);
      wait_time(t + 6);
      check(ln[2] - b == 2, "R8 count", ln[2] - b, 2);
      check(lt[2][b] == t + 1, "R8 first time", lt[2][b], t + 1);
      check(ld[2][b] == 'hA1, "R8 first data", ld[2][b], 'hA1);
      check(lt[2][b+1] == t + 2, "R8 second time", lt[2][b+1], t + 2);
      check(ld[2][b+1] == 'hB2, "R8 second data", ld[2][b+1], 'hB2);
   endtask

   // two interleaved pulse trains with backward-stepping writes
   task automatic t_parallel;
      int s;
      int b0;
      int b1;
      bit st;
      int e0t[4];
      int e1t[4];
      s  = int'(cur_time) + 20;
      b0 = ln[0];
      b1 = ln[1];
      for (int p = 0; p < 2; p++) begin
         send(0, s + 16*p,     1, 0, st);
         send(0, s + 16*p + 4, 0, 0, st);
         send(1, s + 16*p,     1, 0, st);
         send(1, s + 16*p + 8, 0, 0, st);
      end
      wait_time(s + 34);
      e0t = '{s + 1, s + 5, s + 17, s + 21};
      e1t = '{s + 1, s + 9, s + 17, s + 25};
      for (int i = 0; i < 4; i++) begin
         check(lt[0][b0+i] == e0t[i], "R3 ch0 time", lt[0][b0+i], e0t[i]);
         check(ld[0][b0+i] == ((i % 2 == 0) ? 1 : 0), "R3 ch0 data", ld[0][b0+i], (i % 2 == 0) ? 1 : 0);
         check(lt[1][b1+i] == e1t[i], "R4 ch1 time", lt[1][b1+i], e1t[i]);
         check(ld[1][b1+i] == ((i % 2 == 0) ? 1 : 0), "R4 ch1 data", ld[1][b1+i], (i % 2 == 0) ? 1 : 0);
      end
      check(ln[0] - b0 == 4 && ln[1] - b1 == 4, "R4 counts", ln[0] - b0 + ln[1] - b1, 8);
   endtask

   // more same-time events than lanes
   task automatic t_flood;
      int t;
      int b;
      int mask;
      bit st;
      t = int'(cur_time) + 30;
      b = ln[3];
      for (int i = 0; i < LANES + 1; i++) begin
         send(3, t, i, 0, st);
         if (i == LANES) check(!st, "R6 ready held high", int'(st), 0);
      end
      check(seq_err_flag, "R6 flag set", int'(seq_err_flag), 1);
      check(seq_err_chan == 3, "R6 channel", int'(seq_err_chan), 3);
      wait_time(t + 12);
      check(ln[3] - b == LANES, "R5 queued count", ln[3] - b, LANES);
      mask = 0;
      for (int k = 0; k < LANES; k++) begin
         check(lt[3][b+k] == t + 1 + k, "R5 consecutive", lt[3][b+k], t + 1 + k);
         mask |= (1 << ld[3][b+k]);
      end
      check(mask == 'hFF, "R6 dropped event absent", mask, 'hFF);
   endtask

   task automatic t_sticky;
      int t;
      bit st;
      repeat (5) @(negedge clk);
      check(seq_err_flag, "R7 flag sticky", int'(seq_err_flag), 1);
      err_clear = 1'b1;
      @(negedge clk);
      err_clear = 1'b0;
      check(!seq_err_flag, "R7 cleared", int'(seq_err_flag), 0);
      t = int'(cur_time) + 30;
      for (int i = 0; i < LANES + 1; i++) send(1, t, i, (i == LANES), st);
      check(seq_err_flag, "R7 error beats clear", int'(seq_err_flag), 1);
      check(seq_err_chan == 1, "R7 channel", int'(seq_err_chan), 1);
      wait_time(t + 12);
   endtask

   task automatic t_backpressure;
      int t;
      int b;
      bit st;
      bit seen;
      t = int'(cur_time) + 20;
      b = ln[0];
      seen = 0;
      for (int i = 0; i < DEPTH + 1; i++) begin
         send(0, t + 2*i, 16 + i, 0, st);
         seen |= st;
      end
      check(seen, "R9 stall seen", int'(seen), 1);
      wait_time(t + 2*DEPTH + 6);
      check(ln[0] - b == DEPTH + 1, "R9 count", ln[0] - b, DEPTH + 1);
      for (int i = 0; i < DEPTH + 1; i++) begin
         check(lt[0][b+i] == t + 2*i + 1, "R9 time", lt[0][b+i], t + 2*i + 1);
         check(ld[0][b+i] == 16 + i, "R9 data", ld[0][b+i], 16 + i);
      end
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_priority();
      t_parallel();
      t_flood();
      t_sticky();
      t_backpressure();
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule